// File: doc/BRIEF.md
# Dual-Channel Disk I/O Window Decoder

This block sits between a host I/O port and the register files of a two-channel disk controller. Each host access is compared against five programmable address windows: command and control windows for each of the two channels, and one window for the bus-master registers. A hit yields a channel number, a register-block type and an offset from the start of the window. The block then either forwards the access to one of four device slots or passes it to the bus-master register port.

The block keeps one device-select bit per channel. It takes that bit from host writes to the drive/head select register, so it always knows which of the two devices on a channel is addressed. A read aimed at an empty slot returns zero, and a write to an empty slot is dropped. A 32-bit access to the data register is issued to the device as two 16-bit accesses, low half first.

The host issues one request at a time and waits for `rsp_valid` before it sends the next one. Requests that arrive while the block is busy are not accepted.

Top module: `ide_io_decoder`

## Requirements
- R1: After reset, `rsp_valid`, `dec_err`, `dev_valid` and `bm_valid` are low. Both device-select bits are 0. The window bases hold their reset parameters: primary command 0x1F0 (8 bytes), primary control 0x3F4 (4), secondary command 0x170 (8), secondary control 0x374 (4), bus-master 0xC000 (16).
- R2: An access that hits a command or control window reaches the device port. The device port carries the window's offset, `dev_ctrl` (0 for command, 1 for control) and `dev_idx` = 2×channel + select bit. A byte read returns the device's low byte in `rsp_rdata[7:0]`, with the upper bits zero.
- R3: When windows overlap, the lower window index wins. The order is primary command, primary control, secondary command, secondary control, bus-master.
- R4: A command-block write to offset 6 sets that channel's select bit to `req_wdata[4]`. This happens even when the newly selected slot is empty, and the new bit already applies to that same access. No other access changes the select bits.
- R5: An access to a slot whose `dev_present` bit is 0 makes no device-port cycle. A read of such a slot returns 0 with no error.
- R6: A 32-bit access to command offset 0 becomes two 16-bit device cycles on consecutive cycles. The first has `dev_half`=0 and carries data bits 15:0. The second has `dev_half`=1 and carries bits 31:16.
- R7: Size codes are 0 for byte, 1 for 16-bit and 2 for 32-bit. Command offset 0 accepts only 16-bit and 32-bit accesses. Every other command or control offset accepts only bytes. A size that is not allowed raises `dec_err` and returns 0.
- R8: While `io_en` is low, every request completes with `rsp_rdata`=0 and no error. It makes no device or bus-master cycle and does not change the select bits.
- R9: An address that hits no window raises `dec_err` for one cycle, together with `rsp_valid`, and returns 0.
- R10: A configuration write with `cfg_we` and `cfg_idx` 0..4 replaces that window's base only when `cfg_base` is nonzero.
- R11: A bus-master hit makes one `bm_valid` cycle with the window offset. `bm_chan` is 1 when the offset is 8 or more. Read data returns masked to the access size.
- R12: On the bus-master window, sizes 0, 1 and 2 are legal. Size code 3 raises `dec_err` there, as it does on every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decode enable |
| cfg_we | input | 1 | Window base write strobe |
| cfg_idx | input | 3 | Window index for base write |
| cfg_base | input | AW | New base value |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_addr | input | AW | Host I/O address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Request complete |
| rsp_rdata | output | 32 | Read data |
| dec_err | output | 1 | Miss or illegal size, pulses with rsp_valid |
| dev_present | input | 4 | Slot occupancy, bit = device index |
| dev_valid | output | 1 | Device cycle |
| dev_write | output | 1 | Device cycle is a write |
| dev_idx | output | 2 | Device slot |
| dev_ctrl | output | 1 | 0 command block, 1 control block |
| dev_half | output | 1 | High half of a split access |
| dev_off | output | OW | Register offset |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid during dev_valid |
| bm_valid | output | 1 | Bus-master register cycle |
| bm_write | output | 1 | Bus-master write |
| bm_chan | output | 1 | Bus-master channel |
| bm_size | output | 2 | Bus-master access size |
| bm_off | output | OW | Bus-master offset |
| bm_wdata | output | 32 | Bus-master write data |
| bm_rdata | input | 32 | Bus-master read data |

## Verification
The bench's device model returns data that encodes the slot, block type, half and offset. One byte read into each of the four channel windows therefore shows whether channel, block type and offset were decoded correctly. Reads issued after select writes separate the two devices on a channel, and a write that selects an empty slot separates the slot-present check from the select tracking. Sixteen-bit and 32-bit reads and a 32-bit write of the data register show the half ordering. Moving one window base over another tests the priority, and the same accesses with decode disabled, with a zero base and with illegal sizes show which paths have side effects.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
    localparam int NWIN  = 5;
    localparam int NCHAN = 2;
    localparam int W_PCMD = 0;
    localparam int W_PCTL = 1;
    localparam int W_SCMD = 2;
    localparam int W_SCTL = 3;
    localparam int W_BM   = 4;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {BLK_NONE, BLK_CMD, BLK_CTRL, BLK_BM} blk_e;
    typedef enum logic [1:0] {PH_IDLE, PH_DEV_LO, PH_DEV_HI, PH_BM} phase_e;
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
    parameter int AW = 16,
    parameter int OW = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          hit,
    output logic [OW-1:0] off
);
    logic [AW-1:0] diff;

    always_comb begin
        diff = addr - base;
        hit  = (addr >= base) && (diff < size);
        off  = diff[OW-1:0];
    end
endmodule

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_dec_pkg::*;
#(
    parameter int AW = 16,
    parameter int OW = 4,
    parameter logic [NWIN-1:0][AW-1:0] WIN_SIZE = '0
) (
    input  logic [AW-1:0]           addr,
    input  logic [NWIN-1:0][AW-1:0] bases,
    output logic                    hit,
    output blk_e                    blk,
    output logic                    chan,
    output logic [OW-1:0]           off
);
    localparam logic [AW-1:0] BM_HALF = WIN_SIZE[W_BM] >> 1;
    localparam int SW = $clog2(NWIN);

    logic [NWIN-1:0]         hits;
    logic [NWIN-1:0][OW-1:0] offs;
    logic [SW-1:0]           sel;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        ide_win_match #(.AW(AW), .OW(OW)) u_match (
            .addr (addr),
            .base (bases[w]),
            .size (WIN_SIZE[w]),
            .hit  (hits[w]),
            .off  (offs[w])
        );
    end

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                hit = 1'b1;
                sel = SW'(i);
            end
        end
        off = offs[sel];
        unique case (int'(sel))
            W_PCMD, W_SCMD: blk = BLK_CMD;
            W_PCTL, W_SCTL: blk = BLK_CTRL;
            default:        blk = BLK_BM;
        endcase
        if (!hit) blk = BLK_NONE;
        if (int'(sel) == W_BM) chan = (AW'(off) >= BM_HALF);
        else                   chan = (int'(sel) == W_SCMD) || (int'(sel) == W_SCTL);
    end
endmodule

// File: rtl/ide_access_rules.sv
module ide_access_rules
    import ide_dec_pkg::*;
#(
    parameter int OW       = 4,
    parameter int DATA_OFF = 0
) (
    input  blk_e          blk,
    input  logic [OW-1:0] off,
    input  logic [1:0]    size,
    output logic          legal
);
    always_comb begin
        unique case (blk)
            BLK_CMD:  legal = (off == OW'(DATA_OFF)) ? (size == SZ_HALF || size == SZ_WORD)
                                                     : (size == SZ_BYTE);
            BLK_CTRL: legal = (size == SZ_BYTE);
            BLK_BM:   legal = (size != 2'd3);
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
    import ide_dec_pkg::*;
#(
    parameter int AW       = 16,
    parameter int OW       = 4,
    parameter int DW       = 32,
    parameter int DATA_OFF = 0,
    parameter int SEL_OFF  = 6,
    parameter int SEL_BIT  = 4,
    parameter logic [NWIN-1:0][AW-1:0] WIN_SIZE = {16'd16, 16'd4, 16'd8, 16'd4, 16'd8},
    parameter logic [NWIN-1:0][AW-1:0] BASE_RST = {16'hC000, 16'h0374, 16'h0170, 16'h03F4, 16'h01F0}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_idx,
    input  logic [AW-1:0] cfg_base,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          dec_err,
    input  logic [3:0]    dev_present,
    output logic          dev_valid,
    output logic          dev_write,
    output logic [1:0]    dev_idx,
    output logic          dev_ctrl,
    output logic          dev_half,
    output logic [OW-1:0] dev_off,
    output logic [DW/2-1:0] dev_wdata,
    input  logic [DW/2-1:0] dev_rdata,
    output logic          bm_valid,
    output logic          bm_write,
    output logic          bm_chan,
    output logic [1:0]    bm_size,
    output logic [OW-1:0] bm_off,
    output logic [DW-1:0] bm_wdata,
    input  logic [DW-1:0] bm_rdata
);
    localparam int HW = DW / 2;

    typedef struct packed {
        phase_e                  phase;
        logic [NCHAN-1:0]        dsel;
        logic [NWIN-1:0][AW-1:0] base;
        logic                    wr;
        logic [1:0]              size;
        logic                    chan;
        logic                    ctrl;
        logic [OW-1:0]           off;
        logic [1:0]              idx;
        logic [DW-1:0]           wdata;
        logic [DW-1:0]           rdata;
        logic                    rsp_v;
        logic                    err;
    } st_t;

    st_t q, d;

    logic          dec_hit;
    blk_e          dec_blk;
    logic          dec_chan;
    logic [OW-1:0] dec_off;
    logic          size_ok;

    ide_addr_decode #(.AW(AW), .OW(OW), .WIN_SIZE(WIN_SIZE)) u_decode (
        .addr  (req_addr),
        .bases (q.base),
        .hit   (dec_hit),
        .blk   (dec_blk),
        .chan  (dec_chan),
        .off   (dec_off)
    );

    ide_access_rules #(.OW(OW), .DATA_OFF(DATA_OFF)) u_rules (
        .blk   (dec_blk),
        .off   (dec_off),
        .size  (req_size),
        .legal (size_ok)
    );

    always_comb begin
        logic [NCHAN-1:0] nsel;
        logic [1:0]       slot;
        d       = q;
        d.rsp_v = 1'b0;
        d.err   = 1'b0;
        nsel    = q.dsel;
        slot    = '0;

        for (int w = 0; w < NWIN; w++) begin
            if (cfg_we && cfg_idx == 3'(w) && cfg_base != '0) d.base[w] = cfg_base;
        end

        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.wr    = req_write;
                    d.size  = req_size;
                    d.chan  = dec_chan;
                    d.ctrl  = (dec_blk == BLK_CTRL);
                    d.off   = dec_off;
                    d.wdata = req_wdata;
                    d.rdata = '0;
                    if (!io_en) begin
                        d.rsp_v = 1'b1;
                    end else if (!dec_hit || !size_ok) begin
                        d.rsp_v = 1'b1;
                        d.err   = 1'b1;
                    end else if (dec_blk == BLK_BM) begin
                        d.phase = PH_BM;
                    end else begin
                        if (dec_blk == BLK_CMD && req_write && dec_off == OW'(SEL_OFF))
                            nsel[dec_chan] = req_wdata[SEL_BIT];
                        d.dsel = nsel;
                        slot   = {dec_chan, nsel[dec_chan]};
                        d.idx  = slot;
                        if (dev_present[slot]) d.phase = PH_DEV_LO;
                        else                   d.rsp_v = 1'b1;
                    end
                end
            end
            PH_DEV_LO: begin
                if (!q.wr) begin
                    if (q.size == SZ_BYTE) d.rdata = DW'(dev_rdata[7:0]);
                    else                   d.rdata = DW'(dev_rdata);
                end
                if (q.size == SZ_WORD) begin
                    d.phase = PH_DEV_HI;
                end else begin
                    d.phase = PH_IDLE;
                    d.rsp_v = 1'b1;
                end
            end
            PH_DEV_HI: begin
                if (!q.wr) d.rdata[DW-1:HW] = dev_rdata;
                d.phase = PH_IDLE;
                d.rsp_v = 1'b1;
            end
            default: begin
                if (!q.wr) begin
                    unique case (q.size)
                        SZ_BYTE: d.rdata = DW'(bm_rdata[7:0]);
                        SZ_HALF: d.rdata = DW'(bm_rdata[HW-1:0]);
                        default: d.rdata = bm_rdata;
                    endcase
                end
                d.phase = PH_IDLE;
                d.rsp_v = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.base <= BASE_RST;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rdata;
    assign dec_err   = q.err;
    assign dev_valid = (q.phase == PH_DEV_LO) || (q.phase == PH_DEV_HI);
    assign dev_half  = (q.phase == PH_DEV_HI);
    assign dev_write = q.wr;
    assign dev_idx   = q.idx;
    assign dev_ctrl  = q.ctrl;
    assign dev_off   = q.off;
    assign dev_wdata = dev_half ? q.wdata[DW-1:HW] : q.wdata[HW-1:0];
    assign bm_valid  = (q.phase == PH_BM);
    assign bm_write  = q.wr;
    assign bm_chan   = q.chan;
    assign bm_size   = q.size;
    assign bm_off    = q.off;
    assign bm_wdata  = q.wdata;
endmodule

// File: rtl/ide_io_decoder_chk.sv
module ide_io_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_en,
    input logic       req_valid,
    input logic       req_write,
    input logic       rsp_valid,
    input logic       dec_err,
    input logic       dev_valid,
    input logic       dev_half,
    input logic [1:0] dev_idx,
    input logic [3:0] dev_present,
    input logic       bm_valid,
    input logic [1:0] dev_sel
);
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> rsp_valid); // R9

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_valid, bm_valid, rsp_valid})); // R11

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_half) |-> $past(dev_valid && !dev_half)); // R6

    AST_NO_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> dev_present[dev_idx]); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_en && req_valid && !dev_valid && !bm_valid) |=> (!dev_valid && !bm_valid && !dec_err)); // R8

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && io_en) |=> $stable(dev_sel)); // R4
endmodule

bind ide_io_decoder ide_io_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_en       (io_en),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .dec_err     (dec_err),
    .dev_valid   (dev_valid),
    .dev_half    (dev_half),
    .dev_idx     (dev_idx),
    .dev_present (dev_present),
    .bm_valid    (bm_valid),
    .dev_sel     (q.dsel)
);

// File: tb/ide_io_decoder_tb.sv
module ide_io_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_en = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, dec_err;
    logic [31:0]   rsp_rdata;
    logic [3:0]    dev_present = 4'b0111;
    logic          dev_valid, dev_write, dev_ctrl, dev_half;
    logic [1:0]    dev_idx;
    logic [OW-1:0] dev_off;
    logic [15:0]   dev_wdata, dev_rdata;
    logic          bm_valid, bm_write, bm_chan;
    logic [1:0]    bm_size;
    logic [OW-1:0] bm_off;
    logic [31:0]   bm_wdata, bm_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ide_io_decoder u_dut (.*);

    // Device model: data encodes slot, block, half, offset
    assign dev_rdata = dev_valid ? {8'hA5, dev_idx, dev_ctrl, dev_half, dev_off} : 16'h0;
    assign bm_rdata  = bm_valid ? (32'hB0B0_0000 | (32'(bm_chan) << 8) | 32'(bm_off)) : 32'h0;

    logic [19:0] wlog [8];
    int          wcount = 0;
    always @(posedge clk) begin
        if (dev_valid && dev_write) begin
            wlog[{dev_idx, dev_half}] <= {dev_off, dev_wdata};
            wcount <= wcount + 1;
        end
    end

    typedef struct {
        logic [31:0] rd;
        logic        err;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   n_issued = 0;
    int   rsp_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "unexpected response", rsp_rdata, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rsp_rdata == e.rd, {e.tag, " rdata"}, rsp_rdata, e.rd);
                chk(dec_err == e.err, {e.tag, " err"}, 32'(dec_err), 32'(e.err));
            end
            rsp_cnt++;
        end
    end

    task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp_rd,
                          input bit exp_err, input string tag);
        exp_t e;
        e.rd = exp_rd; e.err = exp_err; e.tag = tag;
        sb_q.push_back(e);
        n_issued++;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        wait (rsp_cnt == n_issued);
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int wc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !dec_err && !dev_valid && !bm_valid, "R1 reset outputs",
            {28'h0, rsp_valid, dec_err, dev_valid, bm_valid}, 32'h0);

        // R2 / R1: each channel window with default bases
        access(0, 16'h01F2, 2'd0, 0, 32'h02, 0, "R2 R1 pri cmd");
        access(0, 16'h03F6, 2'd0, 0, 32'h22, 0, "R2 pri ctrl");
        access(0, 16'h0172, 2'd0, 0, 32'h82, 0, "R2 sec cmd");
        access(0, 16'h0376, 2'd0, 0, 32'hA2, 0, "R2 sec ctrl");

        // R11 bus-master channel split
        access(0, 16'hC00A, 2'd2, 0, 32'hB0B0_010A, 0, "R11 bm chan1 word");
        access(0, 16'hC002, 2'd1, 0, 32'h0000_0002, 0, "R11 bm chan0 half");

        // R4 select tracking
        access(1, 16'h01F6, 2'd0, 32'h10, 32'h0, 0, "R4 select write");
        access(0, 16'h01F2, 2'd0, 0, 32'h42, 0, "R4 pri dev1");
        access(0, 16'h0172, 2'd0, 0, 32'h82, 0, "R4 sec unchanged");

        // R6 data register widths
        access(0, 16'h01F0, 2'd1, 0, 32'h0000_A540, 0, "R6 half read");
        access(0, 16'h01F0, 2'd2, 0, 32'hA550_A540, 0, "R6 word read");
        access(1, 16'h01F0, 2'd2, 32'hDEAD_BEEF, 32'h0, 0, "R6 word write");
        chk(wlog[3'b010] == 20'h0BEEF, "R6 low half write", 32'(wlog[3'b010]), 32'h0BEEF);
        chk(wlog[3'b011] == 20'h0DEAD, "R6 high half write", 32'(wlog[3'b011]), 32'h0DEAD);

        // R7 size rules
        access(0, 16'h01F2, 2'd1, 0, 32'h0, 1, "R7 half on byte reg");
        access(0, 16'h01F0, 2'd0, 0, 32'h0, 1, "R7 byte on data reg");
        access(0, 16'h03F6, 2'd1, 0, 32'h0, 1, "R7 half on ctrl");

        // R5 empty slot (slot 3)
        access(1, 16'h0176, 2'd0, 32'h10, 32'h0, 0, "R5 R4 select empty slot");
        access(0, 16'h0172, 2'd0, 0, 32'h0, 0, "R5 read empty slot");
        wc = wcount;
        access(1, 16'h0173, 2'd0, 32'h55, 32'h0, 0, "R5 write empty slot");
        chk(wcount == wc, "R5 no device write", 32'(wcount), 32'(wc));

        // R9 miss, R12 bad size on bus-master
        access(0, 16'h0100, 2'd0, 0, 32'h0, 1, "R9 miss");
        access(0, 16'hC004, 2'd3, 0, 32'h0, 1, "R12 bm size 3");
        access(0, 16'hC004, 2'd0, 0, 32'h04, 0, "R12 bm byte legal");

        // R8 decode disabled
        io_en = 1'b0;
        access(1, 16'h01F6, 2'd0, 32'h00, 32'h0, 0, "R8 disabled select write");
        access(0, 16'h01F2, 2'd0, 0, 32'h0, 0, "R8 disabled read");
        access(0, 16'h0100, 2'd0, 0, 32'h0, 0, "R8 disabled miss");
        io_en = 1'b1;
        access(0, 16'h01F2, 2'd0, 0, 32'h42, 0, "R8 select kept");

        // R10 base update
        cfg(3'd0, 16'h0000);
        access(0, 16'h01F2, 2'd0, 0, 32'h42, 0, "R10 zero base ignored");
        cfg(3'd0, 16'h0200);
        access(0, 16'h0202, 2'd0, 0, 32'h42, 0, "R10 moved base hit");
        access(0, 16'h01F2, 2'd0, 0, 32'h0, 1, "R10 old base miss");
        cfg(3'd0, 16'h01F0);

        // R3 priority with overlapping windows
        cfg(3'd4, 16'h01F0);
        access(0, 16'h01F2, 2'd0, 0, 32'h42, 0, "R3 cmd wins over bm");
        access(0, 16'h01F8, 2'd0, 0, 32'h08, 0, "R3 bm beyond cmd");
        cfg(3'd4, 16'hC000);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule